// File: doc/BRIEF.md
# Prescaled Ripple Timer with Periodic Tick

The block is a free-running binary divider chain of fifteen stages. It advances once every four clock cycles and serves three purposes at once. The eight least significant stages can be read as a byte counter. A wrap of that byte from all ones to zero raises a sticky overflow flag. A two-bit rate field picks one of four upper stages, and the carry out of that stage raises a sticky periodic-tick flag. Its period doubles with each step of the rate field.

Software reaches the block over a one-bit-address register port. Address 0 is a combined status/control byte and address 1 is the read-only count. The status/control byte holds both flags, an enable for each flag, a write-one-to-clear bit for each flag and the rate field. The block drives one registered interrupt request. The request is high while an enabled flag is set.

Top module: `rtmr_top`

## Requirements
- R1: After a synchronous active-low reset, the count reads 0x00, the status/control byte reads 0x00 (both flags clear, both enables off, rate 00), and `irq_o` is low.
- R2: Reading address 1 returns bits 7:0 of the chain. The chain advances by one exactly once every four clock cycles, so N clock edges after reset release the count reads (N/4) mod 256.
- R3: Status/control bit 7 (overflow flag) becomes set on the clock edge at which the count wraps from 0xFF to 0x00, which is every 1024 clocks after reset release.
- R4: Status/control bit 6 (tick flag) becomes set on the edge at which the chain carries out of the selected tap. Rate field bits 1:0 values 00, 01, 10 and 11 select chain bits 10, 11, 12 and 13. The flag therefore sets after 8192, 16384, 32768 and 65536 clocks from reset release.
- R5: Writing address 0 with bit 3 set clears the overflow flag, and writing it with bit 2 set clears the tick flag. Each clear leaves the other flag as it was. Bits 3 and 2 always read as 0.
- R6: Writes to address 1 have no effect on the count. Writes to address 0 can neither set nor clear the flags through bits 7 and 6.
- R7: Writes to address 0 load the overflow enable (bit 5), the tick enable (bit 4) and the rate field (bits 1:0), and these read back as written.
- R8: `irq_o` is the OR of (overflow flag AND overflow enable) and (tick flag AND tick enable), registered. It follows a flag or enable change by one clock.
- R9: When a flag's clear write and that flag's set event fall on the same clock edge, the flag ends set.
- R10: A set flag stays set, whatever time passes, until its clear bit is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 1 | Register select: 0 status/control, 1 count |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A software clear of the overflow flag can land on the same edge at which the byte counter wraps and sets that flag again. The bench keeps its own count of edges since reset. This lets it hold the clear write across edge 3072 exactly, where the third wrap occurs. It then requires the flag to read back set afterwards, so the new event is not lost. It also times enable removal against a set flag, to show that the request drops one clock later while the flag stays sticky.

// File: rtl/rtmr_pkg.sv
// Package: shared register layout for the prescaled ripple timer.
// Assumes an 8-bit register port with a one-bit address.
package rtmr_pkg;
    localparam int REG_W         = 8;
    localparam int BIT_OVF_FLAG  = 7;
    localparam int BIT_TICK_FLAG = 6;
    localparam int BIT_OVF_EN    = 5;
    localparam int BIT_TICK_EN   = 4;
    localparam int BIT_OVF_CLR   = 3;
    localparam int BIT_TICK_CLR  = 2;
    localparam int RATE_LSB      = 0;
    localparam int NUM_FLAGS     = 2;
    localparam int IDX_OVF       = 0;
    localparam int IDX_TICK      = 1;

    typedef enum logic {
        ADDR_CTRL  = 1'b0,
        ADDR_COUNT = 1'b1
    } reg_addr_e;
endpackage

// File: rtl/rtmr_chain.sv
// Module: prescaler plus divider chain.
// Advances the chain once every 2**PRE_LOG2 clocks. Produces the visible
// low byte, the low-byte wrap event and the carry out of the selected tap.
// Assumes TAP_LO + 2**RATE_W - 1 < STAGES and TAP_LO >= VIS_W - 1.
module rtmr_chain #(
    parameter int STAGES   = 15,
    parameter int VIS_W    = 8,
    parameter int PRE_LOG2 = 2,
    parameter int TAP_LO   = 10,
    parameter int RATE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel_i,
    output logic [VIS_W-1:0]  count_o,
    output logic              ovf_evt_o,
    output logic              tick_evt_o
);
    localparam int NTAPS = 1 << RATE_W;

    logic [PRE_LOG2-1:0] pre_q;
    logic [STAGES-1:0]   chain_q;
    logic                adv;
    logic [NTAPS-1:0]    tap_carry;

    assign adv = &pre_q;

    // Purpose: free-running prescaler that gates chain advances.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Purpose: the divider chain itself, one step per prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   chain_q <= '0;
        else if (adv) chain_q <= chain_q + 1'b1;
    end

    // One carry detector per selectable tap stage.
    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        assign tap_carry[g] = adv & (&chain_q[TAP_LO+g:0]);
    end

    assign tick_evt_o = tap_carry[rate_sel_i];
    assign ovf_evt_o  = adv & (&chain_q[VIS_W-1:0]);
    assign count_o    = chain_q[VIS_W-1:0];

    AST_ADV_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !adv) else $error("advance on consecutive cycles"); // R2
    AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(chain_q)) else $error("chain moved without advance"); // R2
    AST_TICK_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt_o |-> ovf_evt_o) else $error("tap carry without byte wrap"); // R4
endmodule

// File: rtl/rtmr_flag.sv
// Module: one sticky event flag with software clear.
// A set event on the same edge as a clear wins, so no event is lost.
module rtmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Purpose: hold the flag, set dominant over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o) else $error("set event lost"); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o) else $error("flag dropped without clear"); // R10
    AST_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(set_i)) else $error("flag rose without event"); // R3
endmodule

// File: rtl/rtmr_ctrl.sv
// Module: status/control register, flag storage and read mux.
// Decodes writes to the control address only. Flags change solely through
// events and clear bits. Assumes VIS_W <= REG_W.
module rtmr_ctrl
    import rtmr_pkg::*;
#(
    parameter int VIS_W  = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [VIS_W-1:0]  count_i,
    input  logic              ovf_evt_i,
    input  logic              tick_evt_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic [RATE_W-1:0] rate_sel_o,
    output logic              ovf_flag_o,
    output logic              tick_flag_o,
    output logic              ovf_en_o,
    output logic              tick_en_o
);
    logic                 ctrl_wr;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_vec;
    logic                 unused_wbits;

    assign ctrl_wr      = wr_i && (addr_i == ADDR_CTRL);
    assign unused_wbits = ^{wdata_i[BIT_OVF_FLAG], wdata_i[BIT_TICK_FLAG]};

    assign set_vec[IDX_OVF]  = ovf_evt_i;
    assign set_vec[IDX_TICK] = tick_evt_i;
    assign clr_vec[IDX_OVF]  = ctrl_wr && wdata_i[BIT_OVF_CLR];
    assign clr_vec[IDX_TICK] = ctrl_wr && wdata_i[BIT_TICK_CLR];

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        rtmr_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[f]),
            .clr_i  (clr_vec[f]),
            .flag_o (flag_vec[f])
        );
    end

    assign ovf_flag_o  = flag_vec[IDX_OVF];
    assign tick_flag_o = flag_vec[IDX_TICK];

    // Purpose: load enables and rate field on control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_en_o   <= 1'b0;
            tick_en_o  <= 1'b0;
            rate_sel_o <= '0;
        end else if (ctrl_wr) begin
            ovf_en_o   <= wdata_i[BIT_OVF_EN];
            tick_en_o  <= wdata_i[BIT_TICK_EN];
            rate_sel_o <= wdata_i[RATE_LSB +: RATE_W];
        end
    end

    // Purpose: read mux; clear bits and spare bits read as zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTRL) begin
            rdata_o[BIT_OVF_FLAG]          = flag_vec[IDX_OVF];
            rdata_o[BIT_TICK_FLAG]         = flag_vec[IDX_TICK];
            rdata_o[BIT_OVF_EN]            = ovf_en_o;
            rdata_o[BIT_TICK_EN]           = tick_en_o;
            rdata_o[RATE_LSB +: RATE_W]    = rate_sel_o;
        end else begin
            rdata_o[VIS_W-1:0] = count_i;
        end
    end

    AST_TICK_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_flag_o) |-> $past(tick_evt_i)) else $error("tick flag without carry"); // R4
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable({ovf_en_o, tick_en_o, rate_sel_o})) else $error("config moved"); // R7
    AST_COUNT_WR_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_COUNT && ovf_flag_o) |=> ovf_flag_o) else $error("count write cleared flag"); // R6
endmodule

// File: rtl/rtmr_irq.sv
// Module: registered interrupt request from enabled flags.
// Adds one clock of latency so the request is glitch-free.
module rtmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_flag_i,
    input  logic ovf_en_i,
    input  logic tick_flag_i,
    input  logic tick_en_i,
    output logic irq_o
);
    // Purpose: register the combined enabled request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= (ovf_flag_i & ovf_en_i) | (tick_flag_i & tick_en_i);
    end

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ovf_en_i || tick_en_i)) else $error("request without enable"); // R8
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag_i && !tick_flag_i) |=> !irq_o) else $error("request without flag"); // R8
endmodule

// File: rtl/rtmr_top.sv
// Module: top of the prescaled ripple timer with periodic tick.
// Ties the chain, register block and request logic together. Register port
// is a simple strobe-qualified write with combinational read data.
module rtmr_top #(
    parameter int STAGES   = 15,
    parameter int VIS_W    = 8,
    parameter int PRE_LOG2 = 2,
    parameter int TAP_LO   = 10,
    parameter int RATE_W   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_o
);
    logic [VIS_W-1:0]  count;
    logic [RATE_W-1:0] rate_sel;
    logic              ovf_evt, tick_evt;
    logic              ovf_flag, tick_flag, ovf_en, tick_en;

    rtmr_chain #(
        .STAGES(STAGES), .VIS_W(VIS_W), .PRE_LOG2(PRE_LOG2),
        .TAP_LO(TAP_LO), .RATE_W(RATE_W)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (rate_sel),
        .count_o    (count),
        .ovf_evt_o  (ovf_evt),
        .tick_evt_o (tick_evt)
    );

    rtmr_ctrl #(.VIS_W(VIS_W), .RATE_W(RATE_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .count_i     (count),
        .ovf_evt_i   (ovf_evt),
        .tick_evt_i  (tick_evt),
        .rdata_o     (reg_rdata),
        .rate_sel_o  (rate_sel),
        .ovf_flag_o  (ovf_flag),
        .tick_flag_o (tick_flag),
        .ovf_en_o    (ovf_en),
        .tick_en_o   (tick_en)
    );

    rtmr_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovf_flag_i  (ovf_flag),
        .ovf_en_i    (ovf_en),
        .tick_flag_i (tick_flag),
        .tick_en_i   (tick_en),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/sim_rtmr_top.sv
`timescale 1ns/1ps
module sim_rtmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int nvec = 0;
    int nbad = 0;
    int ncyc = 0;

    always #2 clk = ~clk;

    // Edges since reset release, kept by the bench.
    always @(posedge clk) begin
        if (!rst_n) ncyc <= 0;
        else        ncyc <= ncyc + 1;
    end

    rtmr_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, ncyc, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        while (ncyc < n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        rd(1'b1, v); chk("R1 count", v, 8'h00);
        rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_count();
        logic [7:0] v;
        for (int i = 0; i < 6; i++) begin
            wr(1'b1, 8'h55 + 8'(i));
            repeat (i) @(negedge clk);
            rd(1'b1, v);
            chk("R2 R6 count", v, (ncyc / 4) % 256);
        end
    endtask

    task automatic t_ovf();
        logic [7:0] v;
        wait_cyc(1023);
        rd(1'b0, v); chk("R3 before wrap", v, 8'h00);
        rd(1'b1, v); chk("R2 count 255", v, 8'hFF);
        wait_cyc(1024);
        rd(1'b0, v); chk("R3 after wrap", v, 8'h80);
        rd(1'b1, v); chk("R2 count wraps", v, 8'h00);
        wait_cyc(1025);
        chk("R8 disabled no irq", irq_o, 0);
        wr(1'b0, 8'h40);
        rd(1'b0, v); chk("R6 flag bits ignored", v, 8'h80);
        wr(1'b0, 8'h08);
        rd(1'b0, v); chk("R5 ovf clear", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R7 enable readback", v, 8'h20);
        wait_cyc(2047);
        rd(1'b0, v); chk("R3 second wrap pending", v, 8'h20);
        wait_cyc(2048);
        rd(1'b0, v); chk("R3 second wrap", v, 8'hA0);
        chk("R8 irq lag", irq_o, 0);
        wait_cyc(2049);
        chk("R8 irq set", irq_o, 1);
        wr(1'b0, 8'h28);
        rd(1'b0, v); chk("R5 clear keeps enable", v, 8'h20);
        chk("R8 irq still high", irq_o, 1);
        wait_cyc(2051);
        chk("R8 irq dropped", irq_o, 0);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        wait_cyc(3071);
        wr(1'b0, 8'h28);
        rd(1'b0, v); chk("R9 set beats clear", v, 8'hA0);
        wait_cyc(3073);
        chk("R8 irq after collide", irq_o, 1);
        wr(1'b0, 8'h00);
        chk("R8 irq one more", irq_o, 1);
        wait_cyc(3075);
        chk("R8 irq off with enable", irq_o, 0);
        rd(1'b0, v); chk("R10 flag sticky", v, 8'h80);
        wr(1'b0, 8'h08);
    endtask

    task automatic t_tick();
        logic [7:0] v;
        do_reset();
        wr(1'b0, 8'h10);
        wait_cyc(8191);
        rd(1'b0, v); chk("R4 rate0 before", (v >> 6) & 1, 0);
        wait_cyc(8192);
        rd(1'b0, v); chk("R4 rate0 at 8192", (v >> 6) & 1, 1);
        chk("R8 tick irq lag", irq_o, 0);
        wait_cyc(8193);
        chk("R8 tick irq", irq_o, 1);
        wait_cyc(8500);
        rd(1'b0, v); chk("R10 tick sticky", v, 8'hD0);
        wr(1'b0, 8'h15);
        rd(1'b0, v); chk("R5 R7 tick clear only", v, 8'h91);
        wait_cyc(16383);
        rd(1'b0, v); chk("R4 rate1 before", (v >> 6) & 1, 0);
        wait_cyc(16384);
        rd(1'b0, v); chk("R4 rate1 at 16384", (v >> 6) & 1, 1);
        wr(1'b0, 8'h16);
        wait_cyc(32767);
        rd(1'b0, v); chk("R4 rate2 before", (v >> 6) & 1, 0);
        wait_cyc(32768);
        rd(1'b0, v); chk("R4 rate2 at 32768", (v >> 6) & 1, 1);
        wr(1'b0, 8'h17);
        rd(1'b0, v); chk("R7 rate3 readback", v & 8'h33, 8'h13);
        wait_cyc(65535);
        rd(1'b0, v); chk("R4 rate3 before", (v >> 6) & 1, 0);
        wait_cyc(65536);
        rd(1'b0, v); chk("R4 rate3 at 65536", (v >> 6) & 1, 1);
        rd(1'b1, v); chk("R2 count at 65536", v, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", ncyc);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_ovf();
        t_irq();
        t_collide();
        t_tick();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule